// File: doc/BRIEF.md
# Indexed ATA Timing Register File

This block keeps the per-drive interface timing bytes for one ATA channel that serves a master and a slave drive. The host never addresses a timing byte directly. It first writes an index byte at one port offset. It then reads or writes the chosen byte through a second port offset. Each drive owns eight contiguous index slots. The slave's slots sit a fixed stride above the master's.

When a transfer mode is chosen, a mode-select strobe names the drive, the mode class and the mode number. In that cycle the block reloads the relevant timing bytes of that drive from built-in tables, which are tuned for a 133 MHz timing clock. The host can still overwrite any timing byte afterwards, for example to clear the UltraDMA hold-time bit or to set the ready-wait and prefetch bits. A status index reports the cable-detect input.

Top module: `ata_tmg_regfile`

## Requirements
- R1: A host write with `host_port` = 1 stores `host_wdata` as the current index. Writes with `host_port` = 0 or 2 change nothing.
- R2: `host_rdata` is a register. It shows the byte at the current index one clock after that index was captured, and it keeps the previous index's byte until then.
- R3: A host write with `host_port` = 3 stores `host_wdata` into the timing byte at the current index. All eight bits are writable, including bit 7 of index 0x10 (hold time) and bits 1:0 of index 0x13 (ready-wait and prefetch enables).
- R4: After reset the index is 0 and `host_rdata` is 0. Each drive's bytes hold the mode 0 values of their table: PIO bytes FB, 2B, AC; multiword DMA bytes DF, 5F; UltraDMA bytes 4A, 0F, D5.
- R5: Master bytes occupy indices 0x0C to 0x13. The slave's byte for the same function sits at the master index plus 0x08. A load or write aimed at one drive leaves the other drive's bytes unchanged.
- R6: A mode strobe with class 0 (PIO) and mode n from 0 to 4 loads indices 0x0C, 0x0D and 0x13 (plus the drive offset) with {FB,2B,AC}, {46,29,A4}, {23,26,64}, {27,0D,35} or {23,09,25} for n = 0 to 4. This replaces any value the host wrote there.
- R7: A mode strobe with class 1 (multiword DMA) and mode n from 0 to 2 loads indices 0x0E and 0x0F (plus offset) with {DF,5F}, {6B,27} or {69,25} for n = 0 to 2.
- R8: A mode strobe with class 2 (UltraDMA) and mode n from 0 to 6 loads indices 0x10, 0x11 and 0x12 (plus offset) with {4A,0F,D5}, {3A,0A,D0}, {2A,07,CD}, {1A,05,CD}, {1A,03,CD}, {1A,02,CB} or {1A,01,CB} for n = 0 to 6.
- R9: A mode strobe outside the tables changes no byte. This covers class 3, PIO above 4, multiword DMA above 2 and UltraDMA 7.
- R10: When a table load and a host data write hit the same byte in one cycle, the table value is kept. A host write to a byte that the load does not touch still takes effect.
- R11: Index 0x0B reads `cable_40` in bit 2 (1 means a 40-conductor cable) and zero in all other bits. Writes to index 0x0B are ignored.
- R12: Any index that is neither a timing byte nor 0x0B reads as zero. Data writes at such an index change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_port | input | 2 | Port offset of a host access: 1 = index, 3 = data |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered byte at the current index |
| mode_stb | input | 1 | Transfer-mode select strobe |
| mode_drive | input | 1 | Target drive of the strobe: 0 master, 1 slave |
| mode_class | input | 2 | 0 PIO, 1 multiword DMA, 2 UltraDMA, 3 none |
| mode_num | input | 3 | Mode number within the class |
| cable_40 | input | 1 | Cable-detect input, high for a 40-conductor cable |

## Verification
The bench targets several boundaries. One is the slave offset: a design with the wrong stride would load or read the master's byte. Another is the last legal mode of each class against the first illegal one: a design that clamps or wraps the mode number would overwrite bytes that must stay unchanged. The bench also fires a load and a host write in the same cycle, both on the same byte and on different bytes. A design with the wrong priority would keep the host byte, and one that blocks the whole bank would lose the unrelated write. Finally it checks the one-cycle read latency, and that writes to the status index and to unused indices are ignored.

// File: rtl/ata_tmg_pkg.sv
package ata_tmg_pkg;
  localparam int DW     = 8;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  // slot order follows index order above the drive base
  localparam int SL_PIO_A = 0;
  localparam int SL_PIO_B = 1;
  localparam int SL_MW_A  = 2;
  localparam int SL_MW_B  = 3;
  localparam int SL_UD_A  = 4;
  localparam int SL_UD_B  = 5;
  localparam int SL_UD_C  = 6;
  localparam int SL_PIO_C = 7;

  localparam logic [2:0] PIO_MAX = 3'd4;
  localparam logic [2:0] MW_MAX  = 3'd2;
  localparam logic [2:0] UD_MAX  = 3'd6;

  typedef enum logic [1:0] {
    CLS_PIO   = 2'd0,
    CLS_MWDMA = 2'd1,
    CLS_UDMA  = 2'd2,
    CLS_NONE  = 2'd3
  } xfer_cls_e;

  typedef logic [SLOTS-1:0][DW-1:0] slot_vec_t;

  function automatic logic [3*DW-1:0] pio_bytes(input logic [2:0] n);
    case (n)
      3'd0:    return 24'hFB2BAC;
      3'd1:    return 24'h4629A4;
      3'd2:    return 24'h232664;
      3'd3:    return 24'h270D35;
      default: return 24'h230925;
    endcase
  endfunction

  function automatic logic [2*DW-1:0] mw_bytes(input logic [2:0] n);
    case (n)
      3'd0:    return 16'hDF5F;
      3'd1:    return 16'h6B27;
      default: return 16'h6925;
    endcase
  endfunction

  function automatic logic [3*DW-1:0] ud_bytes(input logic [2:0] n);
    case (n)
      3'd0:    return 24'h4A0FD5;
      3'd1:    return 24'h3A0AD0;
      3'd2:    return 24'h2A07CD;
      3'd3:    return 24'h1A05CD;
      3'd4:    return 24'h1A03CD;
      3'd5:    return 24'h1A02CB;
      default: return 24'h1A01CB;
    endcase
  endfunction

  function automatic slot_vec_t reset_slots();
    slot_vec_t v;
    logic [3*DW-1:0] p;
    logic [2*DW-1:0] m;
    logic [3*DW-1:0] u;
    p = pio_bytes(3'd0);
    m = mw_bytes(3'd0);
    u = ud_bytes(3'd0);
    v[SL_PIO_A] = p[23:16];
    v[SL_PIO_B] = p[15:8];
    v[SL_PIO_C] = p[7:0];
    v[SL_MW_A]  = m[15:8];
    v[SL_MW_B]  = m[7:0];
    v[SL_UD_A]  = u[23:16];
    v[SL_UD_B]  = u[15:8];
    v[SL_UD_C]  = u[7:0];
    return v;
  endfunction
endpackage

// File: rtl/ata_tmg_table.sv
module ata_tmg_table
  import ata_tmg_pkg::*;
(
  input  xfer_cls_e        cls,
  input  logic [2:0]       num,
  output logic [SLOTS-1:0] ld_mask,
  output slot_vec_t        ld_val
);
  logic [3*DW-1:0] pb;
  logic [2*DW-1:0] mb;
  logic [3*DW-1:0] ub;

  always_comb begin
    pb      = pio_bytes(num);
    mb      = mw_bytes(num);
    ub      = ud_bytes(num);
    ld_mask = '0;
    ld_val  = '0;
    case (cls)
      CLS_PIO: if (num <= PIO_MAX) begin
        ld_mask[SL_PIO_A] = 1'b1;
        ld_mask[SL_PIO_B] = 1'b1;
        ld_mask[SL_PIO_C] = 1'b1;
        ld_val[SL_PIO_A]  = pb[23:16];
        ld_val[SL_PIO_B]  = pb[15:8];
        ld_val[SL_PIO_C]  = pb[7:0];
      end
      CLS_MWDMA: if (num <= MW_MAX) begin
        ld_mask[SL_MW_A] = 1'b1;
        ld_mask[SL_MW_B] = 1'b1;
        ld_val[SL_MW_A]  = mb[15:8];
        ld_val[SL_MW_B]  = mb[7:0];
      end
      CLS_UDMA: if (num <= UD_MAX) begin
        ld_mask[SL_UD_A] = 1'b1;
        ld_mask[SL_UD_B] = 1'b1;
        ld_mask[SL_UD_C] = 1'b1;
        ld_val[SL_UD_A]  = ub[23:16];
        ld_val[SL_UD_B]  = ub[15:8];
        ld_val[SL_UD_C]  = ub[7:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ata_tmg_bank.sv
module ata_tmg_bank
  import ata_tmg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DW-1:0]     wr_data,
  input  logic [SLOTS-1:0]  ld_mask,
  input  slot_vec_t         ld_val,
  output slot_vec_t         q
);
  localparam slot_vec_t RST_VAL = reset_slots();

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (rst)                                    q[s] <= RST_VAL[s];
      else if (ld_mask[s])                        q[s] <= ld_val[s];
      else if (wr_en && wr_slot == SLOT_W'(s))    q[s] <= wr_data;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    // table load beats a same-cycle host write (R10)
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
      ld_mask[s] |=> q[s] == $past(ld_val[s]));
    // untouched bytes keep their value (R9)
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (!ld_mask[s] && !(wr_en && wr_slot == SLOT_W'(s))) |=> $stable(q[s]));
  end
endmodule

// File: rtl/ata_tmg_regfile.sv
module ata_tmg_regfile
  import ata_tmg_pkg::*;
#(
  parameter int         N_DRV      = 2,
  parameter logic [7:0] IDX_BASE   = 8'h0C,
  parameter logic [7:0] DRV_STRIDE = 8'h08,
  parameter logic [7:0] STATUS_IDX = 8'h0B,
  parameter int         CABLE_BIT  = 2,
  parameter logic [1:0] PORT_INDEX = 2'd1,
  parameter logic [1:0] PORT_DATA  = 2'd3,
  localparam int        DRV_W      = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       host_port,
  input  logic             host_we,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             mode_stb,
  input  logic [DRV_W-1:0] mode_drive,
  input  logic [1:0]       mode_class,
  input  logic [2:0]       mode_num,
  input  logic             cable_40
);
  logic [7:0]        idx_q;
  logic [7:0]        rel;
  logic [N_DRV-1:0]  hit;
  logic [SLOT_W-1:0] slot_sel [N_DRV];
  slot_vec_t         bank_q   [N_DRV];
  logic [SLOTS-1:0]  tbl_mask;
  slot_vec_t         tbl_val;
  logic              data_wr;
  logic [DW-1:0]     rd_next;

  assign data_wr = host_we && (host_port == PORT_DATA);
  assign rel     = idx_q - IDX_BASE;

  always_ff @(posedge clk) begin
    if (rst)                                      idx_q <= '0;
    else if (host_we && host_port == PORT_INDEX)  idx_q <= host_wdata;
  end

  ata_tmg_table u_table (
    .cls     (xfer_cls_e'(mode_class)),
    .num     (mode_num),
    .ld_mask (tbl_mask),
    .ld_val  (tbl_val)
  );

  for (genvar d = 0; d < N_DRV; d++) begin : g_drv
    localparam logic [7:0] LO = 8'(d) * DRV_STRIDE;
    logic [7:0]       off;
    logic [SLOTS-1:0] ld_d;

    assign off         = rel - LO;
    assign hit[d]      = off < 8'(SLOTS);
    assign slot_sel[d] = off[SLOT_W-1:0];
    assign ld_d        = (mode_stb && mode_drive == DRV_W'(d)) ? tbl_mask : '0;

    ata_tmg_bank u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (data_wr && hit[d]),
      .wr_slot (slot_sel[d]),
      .wr_data (host_wdata),
      .ld_mask (ld_d),
      .ld_val  (tbl_val),
      .q       (bank_q[d])
    );
  end

  always_comb begin
    rd_next = '0;
    if (idx_q == STATUS_IDX) rd_next[CABLE_BIT] = cable_40;
    for (int d = 0; d < N_DRV; d++)
      if (hit[d]) rd_next = bank_q[d][slot_sel[d]];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_next;
  end

  // index capture through the index port (R1)
  assert_index_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_port == PORT_INDEX) |=> idx_q == $past(host_wdata));
  // status byte mirrors the cable input (R11)
  assert_status_cable_R11: assert property (@(posedge clk) disable iff (rst)
    (idx_q == STATUS_IDX && hit == '0) |=>
      host_rdata == (DW'($past(cable_40)) << CABLE_BIT));
  // unused index reads zero (R12)
  assert_undef_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (idx_q != STATUS_IDX && hit == '0) |=> host_rdata == '0);
endmodule

// File: tb/ata_tmg_regfile_bench.sv
`timescale 1ns/1ps
module ata_tmg_regfile_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_port = 2'd0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       mode_stb = 1'b0;
  logic [0:0] mode_drive = 1'b0;
  logic [1:0] mode_class = 2'd0;
  logic [2:0] mode_num = 3'd0;
  logic       cable_40 = 1'b0;

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  ata_tmg_regfile u_ata_tmg_regfile (
    .clk(clk), .rst(rst), .host_port(host_port), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mode_stb(mode_stb),
    .mode_drive(mode_drive), .mode_class(mode_class), .mode_num(mode_num),
    .cable_40(cable_40)
  );

  // {drive, class, mode, index, expected}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd4, 8'h0C, 8'h23},  // R6 PIO4 master
    {1'b0, 2'd0, 3'd4, 8'h13, 8'h25},  // R6
    {1'b1, 2'd0, 3'd3, 8'h15, 8'h0D},  // R5 R6 slave PIO3
    {1'b1, 2'd0, 3'd3, 8'h0D, 8'h09},  // R5 master untouched
    {1'b0, 2'd1, 3'd2, 8'h0E, 8'h69},  // R7 MW2
    {1'b1, 2'd1, 3'd1, 8'h17, 8'h27},  // R7 slave MW1
    {1'b0, 2'd2, 3'd5, 8'h11, 8'h02},  // R8 UD5
    {1'b0, 2'd2, 3'd7, 8'h11, 8'h02},  // R9 UD7 ignored
    {1'b1, 2'd2, 3'd6, 8'h1A, 8'hCB},  // R8 slave UD6
    {1'b1, 2'd2, 3'd2, 8'h18, 8'h2A},  // R8 slave UD2
    {1'b0, 2'd0, 3'd5, 8'h0C, 8'h23},  // R9 PIO5 ignored
    {1'b0, 2'd3, 3'd0, 8'h0E, 8'h69},  // R9 class 3 ignored
    {1'b0, 2'd2, 3'd0, 8'h12, 8'hD5},  // R8 UD0
    {1'b1, 2'd0, 3'd0, 8'h1B, 8'hAC}   // R6 slave PIO0
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr_port(input logic [1:0] p, input logic [7:0] d);
    host_port = p; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
    wr_port(2'd1, idx);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic mode_load(input logic drv, input logic [1:0] cls, input logic [2:0] n);
    mode_drive = drv; mode_class = cls; mode_num = n; mode_stb = 1'b1;
    @(negedge clk);
    mode_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 rdata after reset", host_rdata, 8'h00);
    rd_reg(8'h0C, v); check("R4 0x0C", v, 8'hFB);
    rd_reg(8'h0D, v); check("R4 0x0D", v, 8'h2B);
    rd_reg(8'h13, v); check("R4 0x13", v, 8'hAC);
    rd_reg(8'h0E, v); check("R4 0x0E", v, 8'hDF);
    rd_reg(8'h0F, v); check("R4 0x0F", v, 8'h5F);
    rd_reg(8'h10, v); check("R4 0x10", v, 8'h4A);
    rd_reg(8'h11, v); check("R4 0x11", v, 8'h0F);
    rd_reg(8'h12, v); check("R4 0x12", v, 8'hD5);
    rd_reg(8'h14, v); check("R4 R5 slave 0x14", v, 8'hFB);
    rd_reg(8'h1B, v); check("R4 R5 slave 0x1B", v, 8'hAC);

    for (int i = 0; i < NV; i++) begin
      mode_load(VEC[i][21], VEC[i][20:19], VEC[i][18:16]);
      rd_reg(VEC[i][15:8], v);
      check($sformatf("mode vector %0d (R5 R6 R7 R8 R9)", i), v, VEC[i][7:0]);
    end

    // R2: one-cycle read latency; 0x0C holds 23, 0x0E holds 69
    rd_reg(8'h0C, v);
    wr_port(2'd1, 8'h0E);
    check("R2 old value before update", host_rdata, 8'h23);
    @(negedge clk);
    check("R2 new value after update", host_rdata, 8'h69);

    // R1: writes at offsets 0 and 2 leave the index alone
    wr_port(2'd0, 8'h0C);
    wr_port(2'd2, 8'h0C);
    @(negedge clk);
    check("R1 index unchanged by offsets 0/2", host_rdata, 8'h69);

    // R3 then R6: host sets ready/prefetch bits, PIO load overwrites
    rd_reg(8'h13, v);
    wr_port(2'd3, 8'h27);
    @(negedge clk);
    check("R3 write 0x13", host_rdata, 8'h27);
    mode_load(1'b0, 2'd0, 3'd2);
    @(negedge clk);
    check("R6 load replaces host bits 0x13", host_rdata, 8'h64);

    // R10: load and write on the same byte
    wr_port(2'd1, 8'h11);
    mode_drive = 1'b0; mode_class = 2'd2; mode_num = 3'd3; mode_stb = 1'b1;
    wr_port(2'd3, 8'h55);
    mode_stb = 1'b0;
    @(negedge clk);
    check("R10 load beats write same byte", host_rdata, 8'h05);
    // R10: load and write on different bytes
    wr_port(2'd1, 8'h0C);
    mode_drive = 1'b0; mode_class = 2'd2; mode_num = 3'd4; mode_stb = 1'b1;
    wr_port(2'd3, 8'h77);
    mode_stb = 1'b0;
    @(negedge clk);
    check("R10 unrelated write kept", host_rdata, 8'h77);
    rd_reg(8'h11, v); check("R10 load applied 0x11", v, 8'h03);

    // R3: hold-time bit writable
    rd_reg(8'h10, v);
    wr_port(2'd3, 8'h9A);
    @(negedge clk);
    check("R3 write 0x10 bit7", host_rdata, 8'h9A);

    // R11: cable status
    cable_40 = 1'b1;
    rd_reg(8'h0B, v); check("R11 cable 40", v, 8'h04);
    wr_port(2'd3, 8'hFF);
    @(negedge clk);
    check("R11 status write ignored", host_rdata, 8'h04);
    cable_40 = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 cable 80", host_rdata, 8'h00);

    // R12: undefined indices
    rd_reg(8'h05, v); check("R12 index 0x05", v, 8'h00);
    rd_reg(8'h1C, v);
    wr_port(2'd3, 8'hAA);
    @(negedge clk);
    check("R12 index 0x1C after write", host_rdata, 8'h00);
    rd_reg(8'h1B, v); check("R12 R5 neighbour unchanged", v, 8'hAC);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule